// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (I2C). It sits in front of a 2048-byte memory made of eight banks of 256 bytes. A fast system clock samples SCL and SDA and derives START, STOP and clock edges from them. The slave takes in a select byte and a byte address. It acknowledges each byte and pulls SDA low through an open-drain enable. A write is held in a small staging buffer. When the master issues STOP, a timed programming cycle copies the buffer into the array.

There are two write modes. In the default mode a burst of up to 16 bytes wraps inside one aligned 16-byte page. When `mode_i` is high, a burst of up to 8 bytes runs on linear addresses. If such a burst crosses an 8-byte row boundary, the programming time doubles. When `wc_i` is high, data bytes are refused and nothing is written. Reads come from an address counter that advances after every byte sent. A master can use a current-address read, or a random read that begins with a dummy write. Either kind can continue as a sequential read.

The bus has no valid/ready handshake. Each byte is paced by SCL and accepted by the acknowledge bit. The slave signals back-pressure only by refusing a byte, which it does while it is programming or while writes are blocked.

Top module: `i2c_ee_slave`

## Requirements
- R1: After reset every array location reads 8'hFF and `sda_oe` is 0.
- R2: A select byte is acknowledged only when bits 7:4 are 4'b1010. Bits 3:1 give the bank, which becomes address bits 10:8, and bit 0 is R/W (1 means read). Any other code gets no acknowledge and SDA is left released.
- R3: A single-byte write acknowledges the select byte, the address and the data byte. The data is stored once STOP arrives. A programming cycle can start only from the data-receive phase.
- R4: A write with `mode_i`=0 stages up to 16 bytes. Address bits 3:0 wrap inside the 16-byte page. Byte 17 and later overwrite the earliest slots.
- R5: A write with `mode_i`=1 stores bytes at linear addresses, so it can cross a page boundary. A 9th byte overwrites the first slot.
- R6: The programming cycle lasts TW_CYCLES clocks. It lasts 2*TW_CYCLES when `mode_i`=1 and the staged bytes span two 8-byte rows, that is, when address bits 10:3 differ.
- R7: While programming, the slave ignores START, acknowledges no select byte and never drives SDA.
- R8: With `wc_i`=1 the select byte and the address are acknowledged, but data bytes are not, and nothing is written. No programming cycle starts.
- R9: A current-address read returns the byte at the address counter and ignores the select bank bits. The counter advances after each byte sent and wraps from 11'h7FF to 11'h000.
- R10: A random read sets the counter with a dummy write. A repeated START and a read select then return the byte at that address.
- R11: In a read, a master ACK makes the slave send the next sequential byte. A master NACK ends the stream and releases SDA.
- R12: Reads behave the same whatever the level of `mode_i`.
- R13: A STOP that arrives after two or more bits of a data byte starts no programming cycle and stores nothing.
- R14: The slave changes `sda_oe` only while synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, unsynchronized |
| sda_i | input | 1 | Bus data line level, unsynchronized |
| mode_i | input | 1 | 1 selects 8-byte linear write bursts, 0 selects 16-byte page bursts |
| wc_i | input | 1 | 1 blocks all data writes |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The programming window cannot be seen from outside, because its only trace at the pins is that select bytes go unacknowledged. The bench therefore times acknowledge polls from the moment of STOP. One poll ends well before the expected end of programming and must be refused. A later poll starts after the expected end and must be acknowledged. A burst that crosses an 8-byte row is timed against twice the window. Staging-buffer wrap and overflow leave their mark only in the array, so the bench sends bursts of 6, 9 and 18 bytes and reads back the addresses each slot should have reached.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_ADDR, ST_WDATA, ST_RDATA} st_t;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ee_wbuf.sv
module i2c_ee_wbuf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int LW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          mb_mode,
  input  logic [LW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [LW:0]   nbytes
);
  localparam logic [LW-1:0] HALF_LAST = LW'(DEPTH/2 - 1);

  logic [DW-1:0]    slot [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [LW-1:0]    wptr;
  logic [LW:0]      cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      vld  <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else if (we) begin
      vld[wptr] <= 1'b1;
      wptr      <= (mb_mode && wptr == HALF_LAST) ? '0 : wptr + LW'(1);
      if (cnt != (LW+1)'(DEPTH)) cnt <= cnt + (LW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (we) slot[wptr] <= wdata;
  end

  assign rd_data  = slot[rd_idx];
  assign rd_valid = vld[rd_idx];
  assign nbytes   = cnt;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= '1;
    end else if (we) begin
      arr[waddr] <= wdata;
    end
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
  import i2c_ee_pkg::*;
#(
  parameter int AW        = 11,
  parameter int PAGE      = 16,
  parameter int TW_CYCLES = 500000,
  parameter int SYNC      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic mode_i,
  input  logic wc_i,
  output logic sda_oe
);
  localparam int BW  = AW - 8;
  localparam int LW  = $clog2(PAGE);
  localparam int BCW = $clog2(2 * TW_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_t st, nxt;
  logic [3:0] cnt;
  logic [7:0] shreg, txreg, rd;
  logic mack, busy, dbl_q, mb_q, buf_we, buf_clr, buf_valid, mem_we;
  logic [BW-1:0] blk;
  logic [AW-1:0] acnt, base, waddr, acnt_wr_next;
  logic [BCW-1:0] bcnt, lim;
  logic [7:0] buf_data;
  logic [LW:0] nbytes, nb_half, span;
  logic [LW-1:0] bidx;
  logic dbl_now, commit_ok;

  i2c_ee_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ee_wbuf #(.DEPTH(PAGE), .DW(8)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .wdata(shreg),
    .mb_mode(mode_i), .rd_idx(bidx), .rd_data(buf_data), .rd_valid(buf_valid),
    .nbytes(nbytes)
  );

  i2c_ee_mem #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(waddr), .wdata(buf_data),
    .raddr(acnt), .rdata(rd)
  );

  // programming-cycle length and commit addressing
  assign nb_half   = (nbytes > (LW+1)'(PAGE/2)) ? (LW+1)'(PAGE/2) : nbytes;
  assign span      = {2'b00, base[LW-2:0]} + nb_half - (LW+1)'(1);
  assign dbl_now   = mode_i && (span >= (LW+1)'(PAGE/2));
  assign commit_ok = (st == ST_WDATA) && (cnt <= 4'd1) && (nbytes != '0);
  assign lim       = dbl_q ? BCW'(2 * TW_CYCLES) : BCW'(TW_CYCLES);
  assign bidx      = bcnt[LW-1:0];
  assign waddr     = mb_q ? base + AW'(bidx)
                          : {base[AW-1:LW], base[LW-1:0] + bidx};
  assign mem_we    = busy && (bcnt < BCW'(PAGE)) && buf_valid;
  assign acnt_wr_next = mode_i ? acnt + AW'(1)
                               : {acnt[AW-1:LW], acnt[LW-1:0] + LW'(1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; nxt <= ST_IDLE; cnt <= '0; shreg <= '0; txreg <= '0;
      mack <= 1'b0; busy <= 1'b0; dbl_q <= 1'b0; mb_q <= 1'b0;
      buf_we <= 1'b0; buf_clr <= 1'b0; blk <= '0; acnt <= '0; base <= '0;
      bcnt <= '0; sda_oe <= 1'b0;
    end else begin
      buf_we  <= 1'b0;
      buf_clr <= 1'b0;
      if (busy) begin
        if (bcnt == lim - BCW'(1)) begin
          busy <= 1'b0;
          bcnt <= '0;
        end else begin
          bcnt <= bcnt + BCW'(1);
        end
      end else if (start_det) begin
        st <= ST_DEV; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        if (commit_ok) begin
          busy <= 1'b1; bcnt <= '0; dbl_q <= dbl_now; mb_q <= mode_i;
        end
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (st == ST_RDATA) begin
            if (cnt == 4'd9) mack <= ~sda_s;
          end else if (cnt < 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (st == ST_RDATA) begin
            if (cnt < 4'd8) begin
              sda_oe <= ~txreg[7];
              txreg  <= {txreg[6:0], 1'b0};
              cnt    <= cnt + 4'd1;
            end else if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              cnt    <= 4'd9;
            end else if (mack) begin
              sda_oe <= ~rd[7];
              txreg  <= {rd[6:0], 1'b0};
              cnt    <= 4'd1;
              acnt   <= acnt + AW'(1);
            end else begin
              st <= ST_IDLE;
            end
          end else if (cnt == 4'd8) begin
            case (st)
              ST_DEV: begin
                if (shreg[7:4] == DEV_CODE) begin
                  sda_oe <= 1'b1; cnt <= 4'd9;
                  if (shreg[0]) nxt <= ST_RDATA;
                  else begin
                    nxt <= ST_ADDR;
                    blk <= shreg[BW:1];
                  end
                end else st <= ST_IDLE;
              end
              ST_ADDR: begin
                sda_oe <= 1'b1; cnt <= 4'd9; nxt <= ST_WDATA;
                acnt <= {blk, shreg}; base <= {blk, shreg}; buf_clr <= 1'b1;
              end
              ST_WDATA: begin
                if (wc_i) st <= ST_IDLE;
                else begin
                  sda_oe <= 1'b1; cnt <= 4'd9; nxt <= ST_WDATA;
                  buf_we <= 1'b1; acnt <= acnt_wr_next;
                end
              end
              default: st <= ST_IDLE;
            endcase
          end else if (cnt == 4'd9) begin
            st <= nxt;
            if (nxt == ST_RDATA) begin
              sda_oe <= ~rd[7];
              txreg  <= {rd[6:0], 1'b0};
              cnt    <= 4'd1;
              acnt   <= acnt + AW'(1);
            end else begin
              sda_oe <= 1'b0;
              cnt    <= '0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk
  import i2c_ee_pkg::*;
#(
  parameter int TW_CYCLES = 16,
  parameter int BCW       = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sda_oe,
  input logic           scl_s,
  input logic           busy,
  input logic [BCW-1:0] bcnt,
  input st_t            st
);
  AST_RST_RELEASED: assert property (@(posedge clk) $rose(rst_n) |-> !sda_oe); // R1

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R14

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!sda_oe && st == ST_IDLE)); // R7

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < BCW'(2 * TW_CYCLES))); // R6

  AST_COMMIT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(st) == ST_WDATA); // R3
endmodule

bind i2c_ee_slave i2c_ee_chk #(.TW_CYCLES(TW_CYCLES), .BCW(BCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .busy(busy), .bcnt(bcnt), .st(st)
);

// File: tb/test_i2c_ee_slave.sv
`timescale 1ns/1ps
module test_i2c_ee_slave;
  localparam int TW = 2000;
  localparam int Q  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, mode = 1'b0, wc = 1'b0;
  logic sda_oe, line;
  int total = 0, bad = 0, cyc = 0, t_stop = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign line = m_sda & ~sda_oe;

  i2c_ee_slave #(.TW_CYCLES(TW)) i_i2c_ee_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(line),
    .mode_i(mode), .wc_i(wc), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bstop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; t_stop = cyc; qw();
  endtask

  task automatic wbit(input logic b);
    m_sda = b; qw(); m_scl = 1'b1; qw(2); m_scl = 1'b0; qw();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); b = line; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic send(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a);
    ack = !a;
  endtask

  task automatic recv(output logic [7:0] v, input bit mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(!mack);
  endtask

  task automatic wait_ready();
    while (cyc < t_stop + 2 * TW + 50) @(negedge clk);
  endtask

  task automatic poll(output bit ack);
    bstart(); send(8'hA0, ack); bstop();
  endtask

  task automatic poll_at(input int dt, input bit exp, input string tag);
    bit a;
    int t0;
    t0 = t_stop;
    while (cyc < t0 + dt) @(negedge clk);
    poll(a);
    chk(a == exp, tag, a, exp);
  endtask

  task automatic wr(input logic [10:0] a, input int n, input logic [7:0] d0,
                    input bit dexp, input string tag);
    bit ad, aa, ax;
    int miss;
    miss = 0;
    bstart();
    send({4'hA, a[10:8], 1'b0}, ad);
    send(a[7:0], aa);
    for (int i = 0; i < n; i++) begin
      send(d0 + 8'(i), ax);
      if (ax != dexp) miss++;
    end
    bstop();
    chk(ad && aa && miss == 0, tag, {ad, aa, miss[7:0]}, {1'b1, 1'b1, 8'h00});
  endtask

  task automatic set_addr(input logic [10:0] a);
    bit x;
    bstart(); send({4'hA, a[10:8], 1'b0}, x); send(a[7:0], x);
  endtask

  task automatic rand_read(input logic [10:0] a, output logic [7:0] d);
    bit x;
    set_addr(a);
    bstart(); send({4'hA, a[10:8], 1'b1}, x); recv(d, 1'b0); bstop();
  endtask

  task automatic cur_read(input logic [2:0] b, output logic [7:0] d);
    bit x;
    bstart(); send({4'hA, b, 1'b1}, x); recv(d, 1'b0); bstop();
  endtask

  task automatic expect_at(input logic [10:0] a, input logic [7:0] e, input string tag);
    logic [7:0] d;
    rand_read(a, d);
    chk(d === e, tag, d, e);
  endtask

  task automatic t_reset();
    chk(sda_oe === 1'b0, "R1 sda released after reset", sda_oe, 0);
    expect_at(11'h123, 8'hFF, "R1 R10 erased content");
  endtask

  task automatic t_bad_dev();
    bit a;
    bstart(); send(8'hB0, a);
    chk(!a && sda_oe === 1'b0, "R2 foreign select code", a, 0);
    bstop();
  endtask

  task automatic t_byte_write();
    logic [7:0] d;
    wr(11'h3C5, 1, 8'h77, 1'b1, "R3 byte write acks");
    wait_ready();
    expect_at(11'h3C5, 8'h77, "R3 R10 byte write readback");
    cur_read(3'd3, d);
    chk(d === 8'hFF, "R9 counter advanced", d, 8'hFF);
  endtask

  task automatic t_busy_timing();
    wr(11'h010, 1, 8'h31, 1'b1, "R6 write for timing");
    poll_at(1500, 1'b0, "R7 busy refuses select");
    poll_at(TW + 100, 1'b1, "R6 ready after window");
  endtask

  task automatic t_page_wrap();
    wr(11'h20C, 6, 8'hA0, 1'b1, "R4 page wrap acks");
    wait_ready();
    expect_at(11'h200, 8'hA4, "R4 wrapped byte 4");
    expect_at(11'h201, 8'hA5, "R4 wrapped byte 5");
    expect_at(11'h210, 8'hFF, "R4 next page untouched");
  endtask

  task automatic t_page_overflow();
    wr(11'h430, 18, 8'h40, 1'b1, "R4 overflow acks");
    wait_ready();
    expect_at(11'h430, 8'h50, "R4 slot 0 overwritten");
    expect_at(11'h431, 8'h51, "R4 slot 1 overwritten");
    expect_at(11'h432, 8'h42, "R4 slot 2 kept");
    expect_at(11'h43F, 8'h4F, "R4 slot 15 kept");
  endtask

  task automatic t_multi_cross();
    mode = 1'b1;
    wr(11'h0FC, 6, 8'hC0, 1'b1, "R5 multibyte acks");
    poll_at(2 * TW - 500, 1'b0, "R6 doubled window still busy");
    poll_at(2 * TW + 100, 1'b1, "R6 doubled window ends");
    wait_ready();
    expect_at(11'h100, 8'hC4, "R5 linear past page R12");
    expect_at(11'h0F0, 8'hFF, "R5 no page wrap");
    mode = 1'b0;
  endtask

  task automatic t_multi_overflow();
    mode = 1'b1;
    wr(11'h500, 9, 8'hD0, 1'b1, "R5 9-byte burst acks");
    poll_at(TW + 100, 1'b1, "R6 single window no row cross");
    wait_ready();
    mode = 1'b0;
    expect_at(11'h500, 8'hD8, "R5 first slot overwritten");
    expect_at(11'h507, 8'hD7, "R5 slot 7 kept");
    expect_at(11'h508, 8'hFF, "R5 no 9th address");
  endtask

  task automatic t_wc();
    bit a;
    wc = 1'b1;
    wr(11'h600, 1, 8'h55, 1'b0, "R8 data refused, select and address acked");
    wc = 1'b0;
    poll(a);
    chk(a, "R8 no programming cycle", a, 1);
    expect_at(11'h600, 8'hFF, "R8 nothing written");
  endtask

  task automatic t_seq_read();
    logic [7:0] d;
    logic [7:0] exp [5];
    bit x;
    int miss;
    exp[0] = 8'hA0; exp[1] = 8'hA1; exp[2] = 8'hA2; exp[3] = 8'hA3; exp[4] = 8'hFF;
    miss = 0;
    set_addr(11'h20C);
    bstart(); send(8'hA5, x);
    for (int i = 0; i < 5; i++) begin
      recv(d, i < 4);
      if (d !== exp[i]) miss++;
    end
    chk(miss == 0, "R11 sequential stream", miss, 0);
    chk(sda_oe === 1'b0, "R11 released after NACK", sda_oe, 0);
    bstop();
    mode = 1'b1;
    expect_at(11'h3C5, 8'h77, "R12 read with mode high");
    mode = 1'b0;
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    wr(11'h000, 1, 8'h11, 1'b1, "R9 write low end");
    wait_ready();
    wr(11'h7FF, 1, 8'h99, 1'b1, "R9 write high end");
    wait_ready();
    expect_at(11'h7FF, 8'h99, "R9 top byte");
    cur_read(3'd5, d);
    chk(d === 8'h11, "R9 counter wraps, bank bits ignored", d, 8'h11);
  endtask

  task automatic t_abort();
    bit x;
    set_addr(11'h650);
    send(8'h12, x);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    bstop();
    poll(x);
    chk(x, "R13 no cycle after mid-byte stop", x, 1);
    expect_at(11'h650, 8'hFF, "R13 nothing stored");
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_dev();
    t_byte_write();
    t_busy_timing();
    wait_ready();
    t_page_wrap();
    t_page_overflow();
    t_multi_cross();
    t_multi_overflow();
    t_wc();
    t_seq_read();
    t_wrap();
    t_abort();
    finish_run();
  end
endmodule